// File: doc/BRIEF.md
# Two-Level Interrupt Event Aggregator

This block gathers single-cycle event pulses from a serial-bus master core and turns them into a small set of interrupt lines for a host. Two families of events, FIFO errors and bus protocol events, each collect in their own sticky status group. Each group is cleared by writing ones to its clear register, and each group shows up as one summary bit in a top-level raw status word. The two data-flow requests, last burst and burst, set raw bits directly, and the top-level clear register clears them.

Software reaches the block through a flat register port. Each register is a seven-bit word. A write is one cycle with `wr_en_i` high. Reads are combinational from `rd_addr_i`. All data pins are plain control and status pins, with no handshake. The word addresses are: 0 raw status (read), 1 mask (read/write), 2 masked status (read), 3 top clear (write), 4 top set (write), 5 error status (read), 6 error clear (write), 7 protocol status (read) and 8 protocol clear (write). A read of a write-only address, or of an unused address, returns zero. A registered interrupt output follows each masked top-level bit.

Top module: `evt_irq_tree`

## Requirements
- R1: After reset, every readable register reads zero and all four interrupt outputs are low.
- R2: A pulse on `err_evt_i[k]` sets bit k of the error status (bit 0 RX underflow, bit 1 RX overflow, bit 2 TX underflow, bit 3 TX overflow). The bit is visible after the capturing clock edge.
- R3: A pulse on `proto_evt_i[k]` sets bit k+3 of the protocol status (bit 3 arbitration lost, bit 4 no acknowledge, bit 5 transmission end, bit 6 transmit-to-receive switch).
- R4: A write to a group clear register clears exactly those status bits written as one, at the same positions as that group's status. All other bits of the group keep their value.
- R5: Raw bit 4 is high while any error status bit is set, and raw bit 5 is high while any protocol status bit is set. Each drops once its group is fully cleared.
- R6: A pulse on `lb_req_i` sets raw bit 2, and a pulse on `b_req_i` sets raw bit 3. Writing one to bit 2 or bit 3 of the top clear register clears that bit.
- R7: When an event and a clear of the same bit land in the same cycle, the bit ends set. This holds for group bits and for top-level bits.
- R8: The mask register holds bits 2 to 5, and its other bits read zero. The masked status equals raw status AND mask.
- R9: Writing one to bits 2 to 5 of the set register forces the matching raw bit high. A forced summary bit stays high until bit 4 or bit 5 of the top clear register is written. That clear does not change the group status. Set bits 0, 1 and 6 have no effect.
- R10: Each of `irq_lb_o`, `irq_b_o`, `irq_err_o` and `irq_proto_o` is registered. Each is high in the cycle after its masked status bit (2, 3, 4, 5 in that order) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt_i | input | 4 | Error event pulses, bit k sets error status bit k |
| proto_evt_i | input | 4 | Protocol event pulses, bit k sets protocol status bit k+3 |
| lb_req_i | input | 1 | Last-burst request pulse |
| b_req_i | input | 1 | Burst request pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 7 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 7 | Register read data |
| irq_lb_o | output | 1 | Interrupt for masked bit 2 |
| irq_b_o | output | 1 | Interrupt for masked bit 3 |
| irq_err_o | output | 1 | Interrupt for masked bit 4 |
| irq_proto_o | output | 1 | Interrupt for masked bit 5 |

## Verification
The hardest case to reach is a collision: an event pulse and a clear write that hit the same bit on the same clock edge. Both group and top-level bits are affected. The stimulus places the pulse and the write strobe in the same cycle on purpose. The bench sweeps every pairing of a four-bit event pattern with a four-bit clear pattern in both groups. It also separates a forced summary bit from real group status by setting and clearing through the top-level registers while the group is still holding events.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W   = 7;
  localparam int ADDR_W  = 4;
  localparam int GRP_N   = 4;
  localparam int ERR_LSB = 0;
  localparam int PRO_LSB = 3;
  localparam int TOP_LSB = 2;
  localparam int TOP_N   = 4;

  localparam logic [ADDR_W-1:0] A_RAW    = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MSKD   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TCLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TSET   = 4'd4;
  localparam logic [ADDR_W-1:0] A_ESTAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_ECLR   = 4'd6;
  localparam logic [ADDR_W-1:0] A_PSTAT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_PCLR   = 4'd8;
endpackage

// File: rtl/evt_subgrp.sv
module evt_subgrp #(
  parameter int N   = 4,
  parameter int LSB = 0,
  parameter int W   = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [W-1:0] stat_o,
  output logic         any_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] clr_m;

  assign clr_m = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_m) | evt_i;
  end

  assign stat_o = {{(W-N){1'b0}}, stat_q} << LSB;
  assign any_o  = |stat_q;

  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R4
  clr_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && evt_i == '0) |=> (stat_q == ($past(stat_q) & ~$past(clr_bits_i))));
endmodule

// File: rtl/evt_toplvl.sv
module evt_toplvl #(
  parameter int W   = 7,
  parameter int LSB = 2,
  parameter int N   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_any_i,
  input  logic         pro_any_i,
  input  logic         lb_req_i,
  input  logic         b_req_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic         set_we_i,
  input  logic [N-1:0] data_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic [N-1:0] irq_o
);
  logic [1:0]   dir_q, force_q;
  logic [N-1:0] mask_q, raw_f, irq_q;
  logic [N-1:0] clr_m, set_m;

  assign clr_m = clr_we_i ? data_i : '0;
  assign set_m = set_we_i ? data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      force_q <= '0;
      mask_q  <= '0;
      irq_q   <= '0;
    end else begin
      dir_q   <= (dir_q & ~clr_m[1:0]) | set_m[1:0] | {b_req_i, lb_req_i};
      force_q <= (force_q & ~clr_m[3:2]) | set_m[3:2];
      if (mask_we_i) mask_q <= data_i;
      irq_q   <= raw_f & mask_q;
    end
  end

  assign raw_f    = {pro_any_i | force_q[1], err_any_i | force_q[0], dir_q};
  assign raw_o    = {{(W-N){1'b0}}, raw_f} << LSB;
  assign mask_o   = {{(W-N){1'b0}}, mask_q} << LSB;
  assign masked_o = raw_o & mask_o;
  assign irq_o    = irq_q;

  // R6
  lb_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req_i |=> raw_o[LSB]);

  // R9
  set_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we_i && data_i[2]) |=> raw_o[LSB+2]);

  // R10
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(mask_o[LSB] && raw_o[LSB]));
endmodule

// File: rtl/evt_irq_tree.sv
module evt_irq_tree
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_N-1:0]  err_evt_i,
  input  logic [GRP_N-1:0]  proto_evt_i,
  input  logic              lb_req_i,
  input  logic              b_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_lb_o,
  output logic              irq_b_o,
  output logic              irq_err_o,
  output logic              irq_proto_o
);
  logic [REG_W-1:0] err_stat, pro_stat, raw, mask, masked;
  logic             err_any, pro_any;
  logic [TOP_N-1:0] irq;

  evt_subgrp #(.N(GRP_N), .LSB(ERR_LSB), .W(REG_W)) u_err (
    .clk(clk), .rst_n(rst_n), .evt_i(err_evt_i),
    .clr_we_i(wr_en_i && wr_addr_i == A_ECLR),
    .clr_bits_i(wr_data_i[ERR_LSB +: GRP_N]),
    .stat_o(err_stat), .any_o(err_any));

  evt_subgrp #(.N(GRP_N), .LSB(PRO_LSB), .W(REG_W)) u_pro (
    .clk(clk), .rst_n(rst_n), .evt_i(proto_evt_i),
    .clr_we_i(wr_en_i && wr_addr_i == A_PCLR),
    .clr_bits_i(wr_data_i[PRO_LSB +: GRP_N]),
    .stat_o(pro_stat), .any_o(pro_any));

  evt_toplvl #(.W(REG_W), .LSB(TOP_LSB), .N(TOP_N)) u_top (
    .clk(clk), .rst_n(rst_n),
    .err_any_i(err_any), .pro_any_i(pro_any),
    .lb_req_i(lb_req_i), .b_req_i(b_req_i),
    .mask_we_i(wr_en_i && wr_addr_i == A_MASK),
    .clr_we_i(wr_en_i && wr_addr_i == A_TCLR),
    .set_we_i(wr_en_i && wr_addr_i == A_TSET),
    .data_i(wr_data_i[TOP_LSB +: TOP_N]),
    .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq));

  always_comb begin
    case (rd_addr_i)
      A_RAW:   rd_data_o = raw;
      A_MASK:  rd_data_o = mask;
      A_MSKD:  rd_data_o = masked;
      A_ESTAT: rd_data_o = err_stat;
      A_PSTAT: rd_data_o = pro_stat;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_lb_o    = irq[0];
  assign irq_b_o     = irq[1];
  assign irq_err_o   = irq[2];
  assign irq_proto_o = irq[3];

  // R5
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stat != '0) |-> raw[4]);
endmodule

// File: tb/evt_irq_tree_bench.sv
module evt_irq_tree_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] err_evt = '0, proto_evt = '0;
  logic lb_req = 1'b0, b_req = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [6:0] wr_data = '0, rd_data;
  logic irq_lb, irq_b, irq_err, irq_proto;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  evt_irq_tree u_evt_irq_tree (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt), .proto_evt_i(proto_evt),
    .lb_req_i(lb_req), .b_req_i(b_req), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_lb_o(irq_lb), .irq_b_o(irq_b), .irq_err_o(irq_err), .irq_proto_o(irq_proto));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic wr(input logic [3:0] a, input logic [6:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] e, input logic [3:0] p, input logic l, input logic b);
    @(negedge clk); err_evt = e; proto_evt = p; lb_req = l; b_req = b;
    @(negedge clk); err_evt = '0; proto_evt = '0; lb_req = 1'b0; b_req = 1'b0;
  endtask

  task automatic irqs(output int v);
    v = int'({irq_proto, irq_err, irq_b, irq_lb});
  endtask

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); chk("R1 read", v, 0);
    end
    irqs(v); chk("R1 irq", v, 0);

    // R2 R4 R5 error group sweep
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        pulse(4'(p), 4'd0, 1'b0, 1'b0);
        rd(5, v); chk("R2 err stat", v, p);
        rd(0, v); chk("R5 err summary", (v >> 4) & 1, int'(p != 0));
        wr(6, 7'(c));
        rd(5, v); chk("R4 err clear", v, p & ~c & 15);
        rd(0, v); chk("R5 err drop", (v >> 4) & 1, int'((p & ~c & 15) != 0));
        wr(6, 7'h0F);
      end
    end

    // R3 R4 R5 protocol group sweep
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        pulse(4'd0, 4'(p), 1'b0, 1'b0);
        rd(7, v); chk("R3 proto stat", v, p << 3);
        wr(8, 7'(c << 3));
        rd(7, v); chk("R4 proto clear", v, (p & ~c & 15) << 3);
        rd(0, v); chk("R5 proto summary", (v >> 5) & 1, int'((p & ~c & 15) != 0));
        wr(8, 7'h78);
      end
    end

    // R6 direct requests
    pulse(4'd0, 4'd0, 1'b1, 1'b0);
    rd(0, v); chk("R6 lb raw", v, 7'h04);
    pulse(4'd0, 4'd0, 1'b0, 1'b1);
    rd(0, v); chk("R6 b raw", v, 7'h0C);
    wr(3, 7'h04);
    rd(0, v); chk("R6 clear lb", v, 7'h08);
    wr(3, 7'h08);
    rd(0, v); chk("R6 clear b", v, 0);

    // R7 collisions
    @(negedge clk); err_evt = 4'hF; wr_en = 1'b1; wr_addr = 6; wr_data = 7'h0F;
    @(negedge clk); err_evt = '0; wr_en = 1'b0;
    rd(5, v); chk("R7 err collide", v, 15);
    wr(6, 7'h0F);
    @(negedge clk); lb_req = 1'b1; wr_en = 1'b1; wr_addr = 3; wr_data = 7'h04;
    @(negedge clk); lb_req = 1'b0; wr_en = 1'b0;
    rd(0, v); chk("R7 lb collide", v, 7'h04);
    wr(3, 7'h04);

    // R9 set register, bits 0 1 6 ignored
    wr(4, 7'h7F);
    rd(0, v); chk("R9 set raw", v, 7'h3C);
    // R8 R10 mask sweep
    for (int m = 0; m < 128; m++) begin
      wr(1, 7'(m));
      rd(1, v); chk("R8 mask readback", v, m & 7'h3C);
      rd(2, v); chk("R8 masked", v, m & 7'h3C);
      @(negedge clk);
      irqs(v); chk("R10 irq", v, (m >> 2) & 15);
    end
    wr(1, 7'h00);
    @(negedge clk);
    irqs(v); chk("R10 irq off", v, 0);
    // R9 top clear of summary does not touch group
    pulse(4'h2, 4'd0, 1'b0, 1'b0);
    wr(3, 7'h3C);
    rd(0, v); chk("R9 forced cleared, group held", v, 7'h10);
    rd(5, v); chk("R9 group kept", v, 2);
    wr(6, 7'h0F);
    rd(0, v); chk("R9 raw empty", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule